// File: doc/BRIEF.md
# Compact Two-Wire Test Link Mode Monitor

This block observes a two-wire compact test link: a clock line and a bidirectional data line. Both lines are sampled in the system clock domain. The block never drives either line. It only classifies what it sees. Whenever the data line toggles while the link clock is high, a toggle counter counts it. At the next rising edge of the link clock the count is judged and then cleared. An escape of six toggles starts the activation sequence. An escape of eight or more returns the link to ordinary four-wire operation.

During activation the block walks the activation bit stream. Each link clock rising edge supplies one bit, and the block reports which activation field that bit belongs to. The sequence is 12 bits long unless bit 8 is zero. In that case the sequence extends to 36 bits and carries extra fields. Once the bit position passes the sequence length, the link enters the single-wire scan mode. On that entry the block raises a one-cycle pulse that a companion TAP tracker uses to jump to its reset state. Both inputs pass through two-flop synchronizers. Each link clock phase must therefore last at least four system clocks.

Top module: `cjtag_link_monitor`

## Requirements
- R1: After reset `link_mode` is 0 (four-wire), and `mode_strobe` and `tap_rst` are low.
- R2: Data-line toggles made while the link clock is low are not counted. Six such toggles followed by a link clock rising edge leave `link_mode` unchanged.
- R3: A toggle count of eight or more, judged at a link clock rising edge, sets `link_mode` to 0. This holds from any mode, including counts far above 15; the counter saturates.
- R4: A count of exactly six sets `link_mode` to 1 (activation start). The bit position restarts, and the judging edge itself supplies activation bit 1. The expected length is 12.
- R5: Counts other than six and below eight (for example 4 or 7) leave `link_mode` unchanged.
- R6: In the 12-bit sequence, bit positions 5 to 8 report code 2 (control field) and positions 9 to 12 report code 10 (check field).
- R7: If the data line is 0 at bit position 8, the expected length becomes 36 from that bit on. Bit 8 itself still reports code 2.
- R8: In the 36-bit sequence the reported codes are: positions 9..13 → 3, 14..16 → 4, 17..18 → 5, 19..23 → 6, 24..25 → 7, 26..27 → 8, 28..32 → 9, 33..36 → 10.
- R9: The first bit position beyond the expected length sets `link_mode` to 11 (single-wire scan). `tap_rst` pulses high for exactly one cycle at that moment. Later link clock edges without an escape leave the mode at 11.
- R10: `mode_strobe` is high for exactly one cycle each time `link_mode` changes, and is low otherwise.
- R11: A six-toggle escape in the middle of activation restarts the sequence at bit position 1 with length 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tckc | input | 1 | Link clock line (asynchronous) |
| tmsc | input | 1 | Link data line (asynchronous, observed only) |
| link_mode | output | 4 | Encoded link mode (codes 0 to 11) |
| mode_strobe | output | 1 | One-cycle pulse on every mode change |
| tap_rst | output | 1 | One-cycle pulse on entry to single-wire scan |

## Verification
The hardest situation to reach is the extended 36-bit walk. It needs an exact six-toggle escape and then a zero placed at precisely bit position 8. The escape's own judging edge already counts as bit 1, so an off-by-one in the stimulus shifts every later field boundary. The bench builds escapes and bits from small tasks that each add exactly one link clock rising edge. It sends the extended stream one bit at a time and checks the reported code at every field boundary. A second escape inside an active sequence shows that the position really restarts.

// File: rtl/cjtag_link_monitor.sv
module cjtag_link_monitor #(
  parameter int CNT_W = 4,
  parameter int POS_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tckc,
  input  logic       tmsc,
  output logic [3:0] link_mode,
  output logic       mode_strobe,
  output logic       tap_rst
);
  localparam logic [3:0] M_STD4  = 4'd0;
  localparam logic [3:0] M_START = 4'd1;
  localparam logic [3:0] M_CTRL  = 4'd2;
  localparam logic [3:0] M_SPARE = 4'd3;
  localparam logic [3:0] M_DEL   = 4'd4;
  localparam logic [3:0] M_REV   = 4'd5;
  localparam logic [3:0] M_STAT  = 4'd6;
  localparam logic [3:0] M_RDY   = 4'd7;
  localparam logic [3:0] M_DLY   = 4'd8;
  localparam logic [3:0] M_FMT   = 4'd9;
  localparam logic [3:0] M_CHK   = 4'd10;
  localparam logic [3:0] M_SCAN1 = 4'd11;

  logic [2:0] ck_sh, dt_sh;
  logic [CNT_W-1:0] esc_cnt;
  logic [POS_W-1:0] pos_q, pos_n, p;
  logic long_q, long_n;
  logic [3:0] mode_q, mode_n;
  logic enter;

  wire ck_s = ck_sh[1];
  wire ck_d = ck_sh[2];
  wire dt_s = dt_sh[1];
  wire dt_d = dt_sh[2];
  wire rise = ck_s & ~ck_d;
  wire tog  = ck_s & ck_d & (dt_s ^ dt_d);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sh <= '0;
      dt_sh <= '0;
    end else begin
      ck_sh <= {ck_sh[1:0], tckc};
      dt_sh <= {dt_sh[1:0], tmsc};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     esc_cnt <= '0;
    else if (rise)                  esc_cnt <= '0;
    else if (tog && esc_cnt != '1)  esc_cnt <= esc_cnt + 1'b1;

  always_comb begin
    mode_n = mode_q;
    pos_n  = pos_q;
    long_n = long_q;
    enter  = 1'b0;
    p      = '0;
    if (rise) begin
      if (esc_cnt >= CNT_W'(8))
        mode_n = M_STD4;
      else if (esc_cnt == CNT_W'(6)) begin
        mode_n = M_START;
        pos_n  = '0;
        long_n = 1'b0;
      end
      if (mode_n >= M_START && mode_n <= M_CHK) begin
        p     = pos_n + 1'b1;
        pos_n = p;
        if (!long_n && p > POS_W'(4)) mode_n = M_CTRL;
        if (p == POS_W'(8) && !dt_s)  long_n = 1'b1;
        if (long_n) begin
          if (p > POS_W'(8))  mode_n = M_SPARE;
          if (p > POS_W'(13)) mode_n = M_DEL;
          if (p > POS_W'(16)) mode_n = M_REV;
          if (p > POS_W'(18)) mode_n = M_STAT;
          if (p > POS_W'(23)) mode_n = M_RDY;
          if (p > POS_W'(25)) mode_n = M_DLY;
          if (p > POS_W'(27)) mode_n = M_FMT;
          if (p > POS_W'(32)) mode_n = M_CHK;
        end else if (p > POS_W'(8)) mode_n = M_CHK;
        if (p > (long_n ? POS_W'(36) : POS_W'(12))) begin
          mode_n = M_SCAN1;
          enter  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q      <= M_STD4;
      pos_q       <= '0;
      long_q      <= 1'b0;
      mode_strobe <= 1'b0;
      tap_rst     <= 1'b0;
    end else begin
      mode_q      <= mode_n;
      pos_q       <= pos_n;
      long_q      <= long_n;
      mode_strobe <= mode_n != mode_q;
      tap_rst     <= enter;
    end

  assign link_mode = mode_q;
endmodule

module cjtag_link_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] link_mode,
  input logic       mode_strobe,
  input logic       tap_rst
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode <= 4'd11);

  p_strobe_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode != $past(link_mode)) |-> mode_strobe);

  p_strobe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == $past(link_mode)) |-> !mode_strobe);

  p_tap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_rst |=> !tap_rst);

  p_tap_on_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_rst |-> (link_mode == 4'd11 && $past(link_mode) != 4'd11));

  p_scan_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_mode) == 4'd11 && link_mode != 4'd11) |->
      (link_mode == 4'd0 || link_mode == 4'd1));
endmodule

bind cjtag_link_monitor cjtag_link_monitor_chk u_chk (.*);

// File: tb/tb_cjtag_link_monitor.sv
module tb_cjtag_link_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tckc = 1'b1;
  logic tmsc = 1'b1;
  logic [3:0] link_mode;
  logic mode_strobe, tap_rst;
  int checks = 0, failures = 0, strobes = 0, taps = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cjtag_link_monitor dut (.clk(clk), .rst_n(rst_n), .tckc(tckc), .tmsc(tmsc),
    .link_mode(link_mode), .mode_strobe(mode_strobe), .tap_rst(tap_rst));

  always @(posedge clk) if (rst_n) begin
    if (mode_strobe) strobes++;
    if (tap_rst) taps++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  // one link bit: clock low with data, then clock high (ends high)
  task automatic send_bit(logic b);
    tckc = 1'b0; tmsc = b; hold(6);
    tckc = 1'b1; hold(6);
  endtask

  // n toggles with clock high, then one judging rising edge
  task automatic escape(int n);
    for (int i = 0; i < n; i++) begin tmsc = ~tmsc; hold(6); end
    tckc = 1'b0; hold(6);
    tckc = 1'b1; hold(6);
  endtask

  task automatic t_reset;
    hold(8);
    chk("R1 mode", link_mode, 0);
    chk("R1 strobe", mode_strobe, 0);
    chk("R1 tap", tap_rst, 0);
    chk("R1 strobe count", strobes, 0);
  endtask

  task automatic t_ignored;
    escape(4);
    chk("R5 count4", link_mode, 0);
    tckc = 1'b0; hold(6);
    for (int i = 0; i < 6; i++) begin tmsc = ~tmsc; hold(6); end
    tckc = 1'b1; hold(6);
    chk("R2 low toggles", link_mode, 0);
    escape(7);
    chk("R5 count7", link_mode, 0);
    chk("R10 no strobes", strobes, 0);
  endtask

  task automatic t_short;
    int s0 = strobes, t0 = taps;
    escape(6);
    chk("R4 start", link_mode, 1);
    for (int j = 2; j <= 13; j++) begin
      send_bit(1'b1);
      if (j == 4)  chk("R6 pos4", link_mode, 1);
      if (j == 5)  chk("R6 pos5", link_mode, 2);
      if (j == 8)  chk("R6 pos8", link_mode, 2);
      if (j == 9)  chk("R6 pos9", link_mode, 10);
      if (j == 12) chk("R6 pos12", link_mode, 10);
    end
    chk("R9 scan", link_mode, 11);
    chk("R9 tap once", taps - t0, 1);
    chk("R10 strobes short", strobes - s0, 4);
    for (int j = 0; j < 5; j++) send_bit(j[0]);
    chk("R9 stays", link_mode, 11);
    chk("R9 no more tap", taps - t0, 1);
    escape(7);
    chk("R5 count7 in scan", link_mode, 11);
    escape(8);
    chk("R3 to std", link_mode, 0);
  endtask

  task automatic t_long;
    int s0 = strobes, t0 = taps;
    escape(6);
    for (int j = 2; j <= 37; j++) begin
      send_bit(j == 8 ? 1'b0 : 1'b1);
      case (j)
        8:  chk("R7 pos8", link_mode, 2);
        9:  chk("R8 pos9", link_mode, 3);
        13: chk("R8 pos13", link_mode, 3);
        14: chk("R8 pos14", link_mode, 4);
        17: chk("R8 pos17", link_mode, 5);
        19: chk("R8 pos19", link_mode, 6);
        24: chk("R8 pos24", link_mode, 7);
        26: chk("R8 pos26", link_mode, 8);
        28: chk("R8 pos28", link_mode, 9);
        32: chk("R8 pos32", link_mode, 9);
        33: chk("R8 pos33", link_mode, 10);
        36: chk("R8 pos36", link_mode, 10);
        default: ;
      endcase
    end
    chk("R9 long scan", link_mode, 11);
    chk("R9 long tap", taps - t0, 1);
    chk("R10 strobes long", strobes - s0, 11);
    escape(20);
    chk("R3 saturated", link_mode, 0);
  endtask

  task automatic t_restart;
    escape(6);
    for (int j = 2; j <= 7; j++) send_bit(1'b1);
    chk("R11 before", link_mode, 2);
    escape(6);
    chk("R11 restart", link_mode, 1);
    for (int j = 2; j <= 4; j++) send_bit(1'b1);
    chk("R11 pos4", link_mode, 1);
    send_bit(1'b1);
    chk("R11 pos5", link_mode, 2);
    for (int j = 6; j <= 12; j++) send_bit(1'b1);
    chk("R11 pos12", link_mode, 10);
    send_bit(1'b1);
    chk("R11 scan", link_mode, 11);
    escape(8);
    chk("R3 final", link_mode, 0);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    t_reset();
    t_ignored();
    t_short();
    t_long();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule